// File: doc/BRIEF.md
# DMA SYNC-Driven Request Terminator

This block sits on the host side of a low-pin-count bus DMA path. A peripheral returns a 4-bit SYNC nibble for each byte it moves. The block reads that nibble and decides three things: whether the internal DMA request toward the legacy DMA controller stays up or drops, whether the rest of the indicated transfer must be abandoned, and whether an error has to be flagged. Bus framing and the DMA controller itself lie outside the block.

A cycle-start strobe opens a transfer. With it the block captures the indicated size, the 16-bit-channel flag and the direction. Each valid SYNC nibble that follows moves the transfer along by one byte or closes it. When a transfer closes, the block emits a single-cycle done pulse. That pulse may come with an abort pulse, which stops the remaining bytes. On a faulted 16-bit write it may also come with a fill strobe whose pseudo-random data replaces the missing upper byte. A peripheral that wants more data returns the "more" code, and the request stays asserted for a later cycle.

Top module: `dma_sync_term`

## Requirements
- R1: After reset, req_o, err_o, done_o, abort_o and fill_en_o are all 0.
- R2: start_i sets req_o and clears err_o from the next cycle. It also captures size_i (byte count minus one), chan16_i and dir_wr_i (1 = peripheral to host), and resets the byte index to 0. A SYNC nibble presented in the same cycle as start_i is ignored.
- R3: Code 4'b1001 on a byte that is not the final one advances the byte index. It produces no done_o pulse and leaves req_o at 1.
- R4: Code 4'b1001 on the final byte gives a done_o pulse with abort_o at 0, and req_o stays at 1.
- R5: On a read (dir_wr_i = 0), an end code (4'b0000 or 4'b1010) on a byte before the final one gives done_o and abort_o together, and req_o drops to 0.
- R6: An end code on the final byte gives done_o with abort_o at 0, and req_o drops to 0.
- R7: On a write, an end code on a byte before the final one marks the following byte as the last. No done_o pulse appears yet. The next ready code then gives done_o, drops req_o, and pulses abort_o only if that byte is not the final one.
- R8: Code 4'b1010 sets err_o. err_o stays at 1 until the next start_i.
- R9: An end code on byte 0 of a multi-byte transfer on a 16-bit channel is an error. In either direction it gives err_o, abort_o and done_o, and req_o drops. On a write, fill_en_o also pulses, and fill_data_o holds a nonzero value taken from a free-running 8-bit maximal-length LFSR.
- R10: SYNC codes other than 4'b0000, 4'b1001 and 4'b1010, and any SYNC nibble while no transfer is open, change nothing at the outputs.
- R11: done_o, abort_o and fill_en_o are single-cycle pulses. abort_o and fill_en_o appear only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Cycle-start strobe |
| size_i | input | SIZE_W | Indicated byte count minus one |
| chan16_i | input | 1 | Transfer runs on a 16-bit channel |
| dir_wr_i | input | 1 | 1 = peripheral to host, 0 = host to peripheral |
| sync_vld_i | input | 1 | SYNC nibble valid |
| sync_i | input | 4 | SYNC nibble |
| req_o | output | 1 | DMA request level toward the controller |
| abort_o | output | 1 | Drop the remaining bytes |
| err_o | output | 1 | Sticky error flag |
| fill_en_o | output | 1 | Fill the upper byte |
| fill_data_o | output | 8 | Upper-byte fill data |
| done_o | output | 1 | Transfer-complete pulse |

## Verification
If the byte index is wrong, done_o and abort_o come out one SYNC early or late. This shows on the very nibble where the final-byte test goes wrong, one cycle after that nibble is sampled. A lost pending-last mark on writes shows as a missing done_o on the byte after an early end code. A wrong captured direction or channel flag shows in the same cycle as abort_o, fill_en_o or err_o. A request that stays up, or drops, against the code shows on req_o at the same edge as done_o.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam logic [3:0] SYNC_END_OK  = 4'b0000;
  localparam logic [3:0] SYNC_MORE    = 4'b1001;
  localparam logic [3:0] SYNC_END_ERR = 4'b1010;

  typedef enum logic [1:0] {
    SK_WAIT    = 2'd0,
    SK_MORE    = 2'd1,
    SK_END_OK  = 2'd2,
    SK_END_ERR = 2'd3
  } sync_kind_e;
endpackage

// File: rtl/dst_sync_decode.sv
module dst_sync_decode
  import dst_pkg::*;
(
  input  logic [3:0]  code_i,
  output sync_kind_e  kind_o
);
  always_comb begin
    unique case (code_i)
      SYNC_END_OK:  kind_o = SK_END_OK;
      SYNC_END_ERR: kind_o = SK_END_ERR;
      SYNC_MORE:    kind_o = SK_MORE;
      default:      kind_o = SK_WAIT;
    endcase
  end
endmodule

// File: rtl/dst_lfsr.sv
module dst_lfsr #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       SEED = 8'hA5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);
  logic fb;

  generate
    if (W == 8) begin : g_w8
      assign fb = q_o[7] ^ q_o[5] ^ q_o[4] ^ q_o[3];
    end else begin : g_wx
      assign fb = q_o[W-1] ^ q_o[W-2];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= SEED;
    else         q_o <= {q_o[W-2:0], fb};
  end
endmodule

// File: rtl/dma_sync_term.sv
module dma_sync_term
  import dst_pkg::*;
#(
  parameter int unsigned SIZE_W    = 2,
  parameter int unsigned FILL_W    = 8,
  parameter logic [7:0]  FILL_SEED = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              chan16_i,
  input  logic              dir_wr_i,
  input  logic              sync_vld_i,
  input  logic [3:0]        sync_i,
  output logic              req_o,
  output logic              abort_o,
  output logic              err_o,
  output logic              fill_en_o,
  output logic [7:0]        fill_data_o,
  output logic              done_o
);
  localparam logic [SIZE_W-1:0] IDX_ZERO = '0;
  localparam logic [SIZE_W-1:0] IDX_ONE  = SIZE_W'(1);

  sync_kind_e          kind;
  logic [FILL_W-1:0]   lfsr_q;
  logic                active_q, pend_q, chan16_q, dir_q;
  logic [SIZE_W-1:0]   idx_q, size_q;

  dst_sync_decode u_dec (.code_i(sync_i), .kind_o(kind));

  dst_lfsr #(.W(FILL_W), .SEED(FILL_SEED[FILL_W-1:0])) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .q_o(lfsr_q)
  );

  logic ev, is_last, is_end, first16, finish, drop, abort_d, fill_d, err_d;

  always_comb begin
    ev      = sync_vld_i && active_q && !start_i && (kind != SK_WAIT);
    is_last = (idx_q == size_q);
    is_end  = (kind == SK_END_OK) || (kind == SK_END_ERR);
    // end code on the low byte of a multi-byte 16-bit channel transfer
    first16 = chan16_q && (idx_q == IDX_ZERO) && (size_q != IDX_ZERO) && is_end;
    finish  = ev && (pend_q || first16 || (is_end && (!dir_q || is_last))
                     || (kind == SK_MORE && is_last));
    drop    = finish && (is_end || pend_q || first16);
    abort_d = finish && !is_last;
    fill_d  = finish && first16 && dir_q;
    err_d   = ev && ((kind == SK_END_ERR) || first16);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      pend_q    <= 1'b0;
      chan16_q  <= 1'b0;
      dir_q     <= 1'b0;
      idx_q     <= '0;
      size_q    <= '0;
      req_o     <= 1'b0;
      err_o     <= 1'b0;
      done_o    <= 1'b0;
      abort_o   <= 1'b0;
      fill_en_o <= 1'b0;
    end else begin
      done_o    <= finish;
      abort_o   <= abort_d;
      fill_en_o <= fill_d;
      if (start_i) begin
        active_q <= 1'b1;
        pend_q   <= 1'b0;
        idx_q    <= '0;
        size_q   <= size_i;
        chan16_q <= chan16_i;
        dir_q    <= dir_wr_i;
        req_o    <= 1'b1;
        err_o    <= 1'b0;
      end else begin
        if (err_d) err_o <= 1'b1;
        if (finish) begin
          active_q <= 1'b0;
          pend_q   <= 1'b0;
          if (drop) req_o <= 1'b0;
        end else if (ev) begin
          idx_q <= idx_q + IDX_ONE;
          if (is_end) pend_q <= 1'b1;  // write: next byte is the last
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fill_data_o <= '0;
    else if (fill_d) fill_data_o <= 8'(lfsr_q);
  end
endmodule

// File: rtl/dst_checker.sv
module dst_checker #(
  parameter int unsigned SIZE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              chan16_i,
  input logic              dir_wr_i,
  input logic              sync_vld_i,
  input logic [3:0]        sync_i,
  input logic              req_o,
  input logic              abort_o,
  input logic              err_o,
  input logic              fill_en_o,
  input logic [7:0]        fill_data_o,
  input logic              done_o
);
  logic unknown;
  assign unknown = (sync_i != 4'b0000) && (sync_i != 4'b1001) && (sync_i != 4'b1010);

  a_r11_abort_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> done_o);
  a_r11_fill_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_o |-> done_o);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_fill_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_o |-> (err_o && fill_data_o != 8'h00));
  a_r2_start_clears_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (req_o && !err_o));
  a_r6_req_falls_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> done_o);
  a_r8_err_rises_on_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(sync_vld_i));
  a_r10_unknown_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_vld_i && !start_i && unknown) |=> (!done_o && $stable(req_o) && $stable(err_o)));
endmodule

bind dma_sync_term dst_checker #(.SIZE_W(SIZE_W)) u_dst_checker (.*);

// File: tb/tb_dma_sync_term.sv
`timescale 1ns/1ps
module tb_dma_sync_term;
  localparam int SIZE_W = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [SIZE_W-1:0] size_i = '0;
  logic              chan16_i = 1'b0;
  logic              dir_wr_i = 1'b0;
  logic              sync_vld_i = 1'b0;
  logic [3:0]        sync_i = 4'h0;
  logic              req_o, abort_o, err_o, fill_en_o, done_o;
  logic [7:0]        fill_data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] fill_a;

  always #2 clk_i = ~clk_i;

  dma_sync_term #(.SIZE_W(SIZE_W)) dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outputs: {req, done, abort, err, fill_en}
  task automatic chk_out(input string req, input logic [4:0] exp);
    chk(req, {3'b0, req_o, done_o, abort_o, err_o, fill_en_o}, {3'b0, exp});
  endtask

  task automatic do_start(input logic [SIZE_W-1:0] sz, input logic c16, input logic wr);
    @(negedge clk_i);
    start_i = 1'b1; size_i = sz; chan16_i = c16; dir_wr_i = wr;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic do_sync(input logic [3:0] code);
    @(negedge clk_i);
    sync_vld_i = 1'b1; sync_i = code;
    @(negedge clk_i);
    sync_vld_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_out("R1 reset outputs", 5'b00000);
  endtask

  task automatic t_more_single;
    do_start(2'd0, 1'b0, 1'b0);
    chk_out("R2 start raises req", 5'b10000);
    do_sync(4'b1001);
    chk_out("R4 more on final byte keeps req", 5'b11000);
    @(negedge clk_i);
    chk_out("R11 done is one cycle", 5'b10000);
  endtask

  task automatic t_read_early;
    do_start(2'd3, 1'b0, 1'b0);
    do_sync(4'b1001);
    chk_out("R3 more mid-transfer", 5'b10000);
    do_sync(4'b0000);
    chk_out("R5 read early end aborts", 5'b01100);
  endtask

  task automatic t_end_final;
    do_start(2'd1, 1'b0, 1'b0);
    do_sync(4'b1001);
    do_sync(4'b0000);
    chk_out("R6 end on final byte", 5'b01000);
  endtask

  task automatic t_write_early;
    do_start(2'd3, 1'b0, 1'b1);
    do_sync(4'b0000);
    chk_out("R7 write end marks next byte", 5'b10000);
    do_sync(4'b1001);
    chk_out("R7 write next byte closes", 5'b01100);
    do_start(2'd1, 1'b0, 1'b1);
    do_sync(4'b0000);
    do_sync(4'b1001);
    chk_out("R7 write closes at final byte", 5'b01000);
  endtask

  task automatic t_err;
    do_start(2'd0, 1'b0, 1'b0);
    do_sync(4'b1010);
    chk_out("R8 end with error", 5'b01010);
    repeat (3) @(negedge clk_i);
    chk_out("R8 err sticky", 5'b00010);
    do_start(2'd0, 1'b0, 1'b0);
    chk_out("R8 start clears err", 5'b10000);
  endtask

  task automatic t_first16;
    do_start(2'd1, 1'b1, 1'b1);
    do_sync(4'b0000);
    chk_out("R9 16-bit first byte write", 5'b01111);
    chk("R9 fill data nonzero", 8'(fill_data_o != 8'h00), 8'h01);
    fill_a = fill_data_o;
    repeat (5) @(negedge clk_i);
    do_start(2'd1, 1'b1, 1'b1);
    do_sync(4'b0000);
    chk("R9 fill data from LFSR changes", 8'(fill_data_o != fill_a), 8'h01);
    do_start(2'd1, 1'b1, 1'b0);
    do_sync(4'b0000);
    chk_out("R9 16-bit first byte read", 5'b01110);
  endtask

  task automatic t_ignore;
    do_start(2'd1, 1'b0, 1'b0);
    do_sync(4'b0101);
    chk_out("R10 unknown code ignored", 5'b10000);
    do_sync(4'b1001);
    do_sync(4'b0000);
    chk_out("R10 index unaffected by unknown", 5'b01000);
    do_sync(4'b1010);
    chk_out("R10 idle sync ignored", 5'b00000);
    @(negedge clk_i);
    start_i = 1'b1; size_i = 2'd0; chan16_i = 1'b0; dir_wr_i = 1'b0;
    sync_vld_i = 1'b1; sync_i = 4'b0000;
    @(negedge clk_i);
    start_i = 1'b0; sync_vld_i = 1'b0;
    chk_out("R2 sync with start ignored", 5'b10000);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_more_single();
    t_read_early();
    t_end_final();
    t_write_early();
    t_err();
    t_first16();
    t_ignore();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule